// File: doc/BRIEF.md
# Configuration Bitbang Sequencer

This block brings up a downstream programmable device over a byte-wide parallel port. After a start pulse it sends a fixed preamble on the port. The preamble is a reboot pattern of eight bytes, sent four times in a row, followed by a ten-byte initialisation pattern. The block then watches one bit of a status byte and waits, with a bounded number of attempts, for the target to report that it is ready to accept configuration data.

Once the target is ready, the block takes configuration bytes from a ready/valid input. It turns each bit into two port bytes: the first drives the configuration clock high, the second drives it low, and both carry the data bit on a separate line. Each input byte therefore yields sixteen port bytes. The run ends in a held done flag when the byte marked last has been fully sent. It ends in a held timeout flag if the ready bit never appears.

Top module: `fpga_cfg_sequencer`

## Requirements
- R1: After reset, out_valid, cfg_ready, done and timeout_err are all 0, and the block stays idle until start is seen high.
- R2: The run begins with 32 port bytes made of the 8-byte pattern 84,84,88,84,88,84,88,84 (hex) repeated four times.
- R3: The reboot bytes are followed by exactly ten bytes: 01, 03, 03 and then seven bytes of 01 (hex).
- R4: After the last preamble byte, status_in bit 5 is sampled once every POLL_GAP cycles. The first sample falls POLL_GAP cycles after the last preamble handshake. The other status bits have no effect.
- R5: If POLL_LIMIT samples in a row find bit 5 clear, timeout_err is raised and no configuration byte is accepted.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change in the next cycle.
- R7: Each configuration byte is sent MSB first as 16 port bytes. For a data bit d, the pair is (d?0x40:0)|0x01 followed by (d?0x40:0). Bit 0 is the clock and bit 6 is the data.
- R8: cfg_ready is 1 only while streaming and when no beat of an earlier byte is still pending. A byte is taken when cfg_valid and cfg_ready are both 1.
- R9: done rises once the 16th port byte of the byte taken with cfg_last=1 has been accepted, and timeout_err stays 0 in that case.
- R10: done and timeout_err hold until the next start. A start in idle, done or timeout state clears them. A start during a run has no effect on the port stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when not busy |
| status_in | input | 8 | Status byte from the target; bit 5 is the ready indication |
| cfg_data | input | 8 | Configuration byte |
| cfg_valid | input | 1 | cfg_data is valid |
| cfg_last | input | 1 | Marks the final configuration byte |
| cfg_ready | output | 1 | Block takes a configuration byte this cycle |
| out_data | output | 8 | Parallel port byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Port accepts out_data this cycle |
| done | output | 1 | Run finished successfully (held) |
| timeout_err | output | 1 | Ready bit never appeared (held) |

## Verification
The bench drives the status byte as 0xDF during polling. A block that decoded the wrong bit, or any set bit, would then start streaming instead of timing out. It measures the poll latency and the timeout latency in cycles, which catches an off-by-one in the attempt count or the poll interval. Back-pressure on the port is random, so a generator that advanced without a handshake, or shifted the wrong end of the byte, would corrupt the captured stream. A start pulse injected in mid-stream would restart the preamble in a design that did not ignore it.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POLL,
    ST_STREAM,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam int BOOT_PAT_LEN = 8;
  localparam int INIT_PAT_LEN = 10;

  // Reboot pattern: even nonzero positions carry 0x88, all others 0x84.
  function automatic logic [7:0] reboot_byte(input logic [2:0] pos);
    reboot_byte = (pos != 3'd0 && !pos[0]) ? 8'h88 : 8'h84;
  endfunction

  // Initialisation pattern: positions 1 and 2 raise bit 1, all others 0x01.
  function automatic logic [7:0] init_byte(input logic [3:0] pos);
    init_byte = (pos == 4'd1 || pos == 4'd2) ? 8'h03 : 8'h01;
  endfunction

  // One port beat of a configuration bit: data on bit 6, clock on bit 0.
  // Phase 0 is the clock-high beat, phase 1 the clock-low beat.
  function automatic logic [7:0] beat_byte(input logic d, input logic phase);
    beat_byte = {1'b0, d, 5'b00000, ~phase};
  endfunction

endpackage

// File: rtl/cfgseq_preamble.sv
module cfgseq_preamble
  import cfgseq_pkg::*;
#(
  parameter int REPEATS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       advance,
  output logic [7:0] pat_byte,
  output logic       pat_last
);
  localparam int BOOT_TOTAL = REPEATS * BOOT_PAT_LEN;
  localparam int TOTAL      = BOOT_TOTAL + INIT_PAT_LEN;
  localparam int IW         = $clog2(TOTAL + 1);

  logic [IW-1:0] idx;
  logic [IW-1:0] init_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign init_pos = idx - IW'(BOOT_TOTAL);

  always_comb begin
    if (int'(idx) < BOOT_TOTAL) pat_byte = reboot_byte(idx[2:0]);
    else                        pat_byte = init_byte(init_pos[3:0]);
  end

  assign pat_last = (idx == IW'(TOTAL - 1));

endmodule

// File: rtl/cfgseq_poller.sv
module cfgseq_poller #(
  parameter int GAP   = 3,
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ready_bit,
  output logic tick,
  output logic found,
  output logic expired
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int TW = $clog2(LIMIT + 1);

  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;

  assign tick    = active && (gap_cnt == GW'(GAP - 1));
  assign found   = tick && ready_bit;
  assign expired = tick && !ready_bit && (tries == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      tries   <= '0;
    end else if (!active) begin
      gap_cnt <= '0;
      tries   <= '0;
    end else if (tick) begin
      gap_cnt <= '0;
      tries   <= tries + 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfgseq_serializer.sv
module cfgseq_serializer
  import cfgseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic [7:0]    beat_data,
  output logic          beat_valid,
  input  logic          beat_take,
  output logic          byte_end,
  output logic          stream_end
);
  localparam int BEATS = 2 * DW;
  localparam int BW    = $clog2(BEATS);

  logic [DW-1:0] shreg;
  logic [BW-1:0] beat;
  logic          loaded;
  logic          last_q;
  logic          accept;
  logic          took;

  assign in_ready   = enable && !loaded;
  assign accept     = in_valid && in_ready;
  assign beat_valid = loaded;
  assign took       = beat_take && loaded;
  assign beat_data  = beat_byte(shreg[DW-1], beat[0]);
  assign byte_end   = took && (beat == BW'(BEATS - 1));
  assign stream_end = byte_end && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      beat   <= '0;
      loaded <= 1'b0;
      last_q <= 1'b0;
    end else if (accept) begin
      shreg  <= in_data;
      beat   <= '0;
      loaded <= 1'b1;
      last_q <= in_last;
    end else if (took) begin
      if (byte_end) begin
        loaded <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
      if (beat[0]) shreg <= shreg << 1;
    end
  end

endmodule

// File: rtl/fpga_cfg_sequencer.sv
module fpga_cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter int REBOOT_REPEATS = 4,
  parameter int POLL_GAP       = 3,
  parameter int POLL_LIMIT     = 10000,
  parameter int READY_BIT      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] status_in,
  input  logic [7:0] cfg_data,
  input  logic       cfg_valid,
  input  logic       cfg_last,
  output logic       cfg_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       done,
  output logic       timeout_err
);
  seq_state_t state;

  logic [7:0] pre_byte;
  logic       pre_last;
  logic       pre_phase;
  logic       pre_fire;
  logic       poll_active;
  logic       poll_tick;
  logic       poll_found;
  logic       poll_expired;
  logic       stream_phase;
  logic [7:0] ser_byte;
  logic       ser_valid;
  logic       ser_byte_end;
  logic       ser_end;
  logic       may_start;

  assign pre_phase    = (state == ST_PRE);
  assign poll_active  = (state == ST_POLL);
  assign stream_phase = (state == ST_STREAM);
  assign pre_fire     = pre_phase && out_ready;
  assign may_start    = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);

  cfgseq_preamble #(.REPEATS(REBOOT_REPEATS)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!pre_phase),
    .advance  (pre_fire),
    .pat_byte (pre_byte),
    .pat_last (pre_last)
  );

  cfgseq_poller #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (poll_active),
    .ready_bit (status_in[READY_BIT]),
    .tick      (poll_tick),
    .found     (poll_found),
    .expired   (poll_expired)
  );

  cfgseq_serializer #(.DW(8)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (stream_phase),
    .in_data    (cfg_data),
    .in_valid   (cfg_valid),
    .in_last    (cfg_last),
    .in_ready   (cfg_ready),
    .beat_data  (ser_byte),
    .beat_valid (ser_valid),
    .beat_take  (out_ready),
    .byte_end   (ser_byte_end),
    .stream_end (ser_end)
  );

  assign out_valid   = pre_phase || ser_valid;
  assign out_data    = pre_phase ? pre_byte : (ser_valid ? ser_byte : 8'h00);
  assign done        = (state == ST_DONE);
  assign timeout_err = (state == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_PRE:    if (pre_fire && pre_last) state <= ST_POLL;
        ST_POLL: begin
          if (poll_found)        state <= ST_STREAM;
          else if (poll_expired) state <= ST_FAIL;
        end
        ST_STREAM: if (ser_end) state <= ST_DONE;
        default:   if (may_start && start) state <= ST_PRE;
      endcase
    end
  end

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] status_in,
  input logic       cfg_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       timeout_err,
  input logic       poll_active,
  input logic       poll_found,
  input logic       ser_valid
);
  // R6: a stalled beat is held unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8: no input byte is taken while beats are pending
  p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> !out_valid);

  // R7: stream beats use only the clock and data lines
  p_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (out_data & 8'hBE) == 8'h00);

  // R7: a clock-high beat is followed by its clock-low twin with the same data
  p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && out_ready && out_data[0]
      |=> out_valid && !out_data[0] && (out_data[6] == $past(out_data[6])));

  // R10: the two outcome flags never coexist
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));

  // R9: done holds until a start arrives
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R5: the timeout only follows polling
  p_err_from_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(poll_active));

  // R4: polling passes only with the ready bit set
  p_poll_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_found |-> status_in[5]);
endmodule

bind fpga_cfg_sequencer cfgseq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .status_in   (status_in),
  .cfg_ready   (cfg_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .done        (done),
  .timeout_err (timeout_err),
  .poll_active (poll_active),
  .poll_found  (poll_found),
  .ser_valid   (ser_valid)
);

// File: tb/sim_fpga_cfg_sequencer.sv
module sim_fpga_cfg_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 3;
  localparam int LIMIT      = 10000;
  localparam int REP        = 4;
  localparam int PRE_LEN    = REP * 8 + 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic [7:0] cfg_data = 8'h00;
  logic       cfg_valid = 1'b0;
  logic       cfg_last = 1'b0;
  logic       cfg_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       done;
  logic       timeout_err;

  fpga_cfg_sequencer #(
    .REBOOT_REPEATS(REP), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .READY_BIT(5)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .status_in(status_in),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_last(cfg_last),
    .cfg_ready(cfg_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int hold_bad = 0;
  int gate_bad = 0;
  logic [7:0] src[$];
  logic [7:0] cap[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pre(input int i);
    int j;
    if (i < REP * 8) begin
      j = i % 8;
      return (j == 2 || j == 4 || j == 6) ? 8'h88 : 8'h84;
    end
    j = i - REP * 8;
    return (j == 1 || j == 2) ? 8'h03 : 8'h01;
  endfunction

  function automatic logic [7:0] exp_beat(input logic [7:0] b, input int beat);
    logic d;
    d = b[7 - beat / 2];
    return (d ? 8'h40 : 8'h00) + ((beat % 2 == 0) ? 8'h01 : 8'h00);
  endfunction

  // mode 0: ready bit always present; 1: status 0xDF forever; 2: ready bit after `late` cycles
  task automatic run(input int mode, input int late, input bit mid_start,
                     output int lat, output bit ready_seen);
    int idx;
    bit pend;
    int since;
    bit stall;
    logic [7:0] held;
    cap.delete();
    idx = 0; pend = 0; since = -1; stall = 0; held = 8'h00;
    lat = -1; ready_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) idx++;
      if (since >= 0) since++;
      case (mode)
        0:       status_in = 8'h20;
        1:       status_in = 8'hDF;
        default: status_in = (since >= late) ? 8'h20 : 8'h00;
      endcase
      cfg_valid = (idx < src.size()) && ($urandom % 3 != 0);
      cfg_data  = (idx < src.size()) ? src[idx] : 8'h00;
      cfg_last  = (idx == src.size() - 1);
      out_ready = ($urandom % 4 != 0);
      start     = mid_start && (cap.size() == PRE_LEN + 20);
      if (stall && !(out_valid && out_data == held)) hold_bad++;
      stall = out_valid && !out_ready;
      held  = out_data;
      if (cfg_ready && out_valid) gate_bad++;
      if (cfg_ready) ready_seen = 1;
      if (lat < 0 && since >= 0 && (cfg_ready || timeout_err)) lat = since;
      if (out_valid && out_ready) begin
        cap.push_back(out_data);
        if (cap.size() == PRE_LEN) since = 0;
      end
      pend = cfg_valid && cfg_ready;
      if (done || timeout_err) break;
    end
    cfg_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
  endtask

  task automatic check_stream(input string tag);
    int bad_boot, bad_init, bad_str;
    bad_boot = 0; bad_init = 0; bad_str = 0;
    chk(cap.size() == PRE_LEN + 16 * src.size(), "R7", {tag, " length"},
        cap.size(), PRE_LEN + 16 * src.size());
    if (cap.size() == PRE_LEN + 16 * src.size()) begin
      for (int i = 0; i < REP * 8; i++) if (cap[i] != exp_pre(i)) bad_boot++;
      for (int i = REP * 8; i < PRE_LEN; i++) if (cap[i] != exp_pre(i)) bad_init++;
      for (int b = 0; b < src.size(); b++)
        for (int k = 0; k < 16; k++)
          if (cap[PRE_LEN + 16 * b + k] != exp_beat(src[b], k)) bad_str++;
    end
    chk(bad_boot == 0, "R2", {tag, " reboot mismatches"}, bad_boot, 0);
    chk(bad_init == 0, "R3", {tag, " init mismatches"}, bad_init, 0);
    chk(bad_str == 0, "R7", {tag, " stream mismatches"}, bad_str, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    bit rs;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk(!out_valid && !cfg_ready && !done && !timeout_err, "R1", "reset outputs",
        {out_valid, cfg_ready, done, timeout_err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!out_valid && !done && !timeout_err, "R1", "idle without start",
        {out_valid, done, timeout_err}, 0);

    // Directed bytes, ready bit present at once
    src = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
    run(0, 0, 0, lat, rs);
    chk(lat == GAP + 1, "R4", "poll latency", lat, GAP + 1);
    check_stream("directed");
    chk(done && !timeout_err, "R9", "done after last byte", {done, timeout_err}, 2);
    repeat (20) @(negedge clk);
    chk(done && !out_valid && !cfg_ready, "R10", "done held",
        {done, out_valid, cfg_ready}, 4);

    // Random bytes with a start pulse in mid-stream
    src.delete();
    for (int i = 0; i < 12; i++) src.push_back(8'($urandom));
    run(0, 0, 1, lat, rs);
    chk(!timeout_err, "R10", "flags after restart", timeout_err, 0);
    check_stream("random+midstart");
    chk(done, "R9", "done random", done, 1);

    // Timeout: every status bit except the ready bit set
    src = '{8'h3C};
    run(1, 0, 0, lat, rs);
    chk(timeout_err && !done, "R5", "timeout flags", {done, timeout_err}, 1);
    chk(lat == LIMIT * GAP + 1, "R5", "timeout latency", lat, LIMIT * GAP + 1);
    chk(!rs, "R4", "other status bits ignored", rs, 0);
    chk(cap.size() == PRE_LEN, "R5", "no stream after timeout", cap.size(), PRE_LEN);
    repeat (10) @(negedge clk);
    chk(timeout_err, "R10", "timeout held", timeout_err, 1);

    // Late ready bit, well inside the limit
    src = '{8'h5A, 8'hC3};
    run(2, 200, 0, lat, rs);
    chk(done && !timeout_err, "R10", "start clears timeout", {done, timeout_err}, 2);
    chk(lat > 200 && lat <= 200 + GAP + 1, "R4", "late ready latency", lat, 200 + GAP);
    check_stream("late");

    // Single random byte
    src = '{8'($urandom)};
    run(0, 0, 0, lat, rs);
    check_stream("single");
    chk(done, "R9", "done single", done, 1);

    chk(hold_bad == 0, "R6", "stalled beat changed", hold_bad, 0);
    chk(gate_bad == 0, "R8", "ready with pending beats", gate_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule